// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block keeps the five access keys of a secure serial memory and judges every key that a command sequencer presents. On a one-cycle request strobe the sequencer supplies an operation code, a slot number and a 64-bit candidate key. One cycle later the block reports match or mismatch and its current lockout state.

It also runs the two-pass key change. The new key is committed only when both entries agree and the slot's current key was proven just before. It serves the reset-device and reset-password commands, which use the dedicated reset key. It counts wrong attempts and locks out both array access keys once the tolerance is spent. Lockout, and a successful reset-password command, raise a one-cycle pulse that tells the memory to clear both arrays.

Key storage is plain registers. There is no path that returns a stored key.

Top module: `pwd_guard`

## Requirements
- R1: During and after synchronous reset, `res_valid`, `res_match`, `locked`, `wipe_req` and `commit_req` are low. All five slots hold zero, so a CHECK with key 0 matches any slot.
- R2: Operation codes are 0 CHECK, 1 NEW_FIRST, 2 NEW_SECOND, 3 RESET_DEVICE and 4 RESET_KEYS. Slot codes are 0 read-array-0, 1 read-array-1, 2 write-array-0, 3 write-array-1 and 4 reset. Every strobe gives `res_valid` high for exactly the next cycle. Operation codes 5 to 7 report a mismatch and change no state. Slot codes 5 to 7 never match.
- R3: CHECK reports a match exactly when the candidate equals the key stored in the addressed slot, unless lockout forbids it (R5).
- R4: Each mismatching CHECK, RESET_DEVICE or RESET_KEYS advances the failure count, in any mix of slots. Any match clears the count. Eight failures in a row are tolerated.
- R5: The ninth failure in a row sets `locked` and raises `wipe_req` for one cycle. While locked, CHECK on slots 0 to 3 never matches, failures are not counted, and stored keys are unchanged.
- R6: While locked, the reset slot still matches. RESET_DEVICE with the correct reset key clears `locked` and the count without `wipe_req` and without changing any key. With a wrong key it leaves `locked` set.
- R7: RESET_KEYS with the correct reset key sets all five slots to zero, pulses `wipe_req` for one cycle, and clears the count and `locked`, whether or not the block was locked.
- R8: A change is the sequence CHECK hit on slot S, then NEW_FIRST on S, then NEW_SECOND on S with the same key. The second step then matches. The last step matches, stores the key in S and pulses `commit_req` for one cycle.
- R9: A NEW_SECOND whose key differs from the NEW_FIRST key is discarded with a mismatch and no `commit_req`, and the old key stays. The same applies to a NEW_FIRST or NEW_SECOND that is out of order, addressed to a different slot, or separated from the preceding step by any other request.
- R10: NEW_FIRST, NEW_SECOND and illegal operation codes never change the failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Operation code (R2) |
| req_slot | input | 3 | Slot code (R2) |
| req_key | input | 64 | Candidate or new key |
| res_valid | output | 1 | Result present, the cycle after a strobe |
| res_match | output | 1 | Result: candidate accepted |
| locked | output | 1 | Lockout state |
| wipe_req | output | 1 | One-cycle request to clear both arrays |
| commit_req | output | 1 | One-cycle notice that a new key was stored |

## Verification
On every cycle the assertions check the following. The failure count never passes its limit. Lockout holds until an unlock. Lockout engages together with a wipe pulse. A strobe is answered in the next cycle. A commit always comes with a match. A locked array slot never reports a match.

Only the bench's scenarios can show the rest. These are that exactly the ninth failure locks, and that the keys survive lockout and reset-device. They also cover key content after a commit or a discarded change, and the zeroing done by reset-keys. The bench's reference model follows all of these through mixed sequences.

// File: rtl/pwd_guard_pkg.sv
package pwd_guard_pkg;
  typedef enum logic [2:0] {
    OP_CHECK    = 3'd0,
    OP_NEW1     = 3'd1,
    OP_NEW2     = 3'd2,
    OP_RST_DEV  = 3'd3,
    OP_RST_KEYS = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AUTH  = 2'd1,
    PH_HAVE1 = 2'd2
  } phase_e;
endpackage

// File: rtl/pwd_guard_store.sv
module pwd_guard_store #(
  parameter int KEY_W  = 64,
  parameter int NSLOT  = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_all,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic [KEY_W-1:0]  key,
  output logic [NSLOT-1:0]  eq
);
  // one register per slot; all must clear together, so no RAM here
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [KEY_W-1:0] val;
    always_ff @(posedge clk) begin
      if (rst || zero_all)
        val <= '0;
      else if (wr_en && wr_slot == SLOT_W'(g))
        val <= wr_data;
    end
    assign eq[g] = (val == key);
  end
endmodule

// File: rtl/pwd_guard_tries.sv
module pwd_guard_tries #(
  parameter int MAX_FAIL = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fail,
  input  logic pass,
  input  logic unlock,
  output logic locked,
  output logic wipe
);
  localparam int CNT_W = $clog2(MAX_FAIL + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
      wipe   <= 1'b0;
    end else begin
      wipe <= 1'b0;
      if (unlock) begin
        cnt    <= '0;
        locked <= 1'b0;
      end else if (!locked) begin
        if (pass)
          cnt <= '0;
        else if (fail) begin
          if (cnt == CNT_W'(MAX_FAIL)) begin
            locked <= 1'b1;
            wipe   <= 1'b1;
          end else
            cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_FAIL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_FAIL)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (locked && !unlock) |=> locked); // R5
  AST_WIPE_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> wipe); // R5
endmodule

// File: rtl/pwd_guard_stage.sv
module pwd_guard_stage #(
  parameter int KEY_W  = 64,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [KEY_W-1:0]  req_key,
  input  logic              check_hit,
  output logic              new1_ok,
  output logic              new2_ok
);
  import pwd_guard_pkg::*;
  phase_e            phase;
  logic [SLOT_W-1:0] st_slot;
  logic [KEY_W-1:0]  st_key;

  assign new1_ok = (phase == PH_AUTH)  && (st_slot == req_slot);
  assign new2_ok = (phase == PH_HAVE1) && (st_slot == req_slot) && (st_key == req_key);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      st_slot <= '0;
      st_key  <= '0;
    end else if (req_valid) begin
      phase <= PH_IDLE;
      if (req_op == OP_CHECK && check_hit) begin
        phase   <= PH_AUTH;
        st_slot <= req_slot;
      end else if (req_op == OP_NEW1 && new1_ok) begin
        phase  <= PH_HAVE1;
        st_key <= req_key;
      end
    end
  end
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard #(
  parameter int KEY_W    = 64,
  parameter int NSLOT    = 5,
  parameter int SLOT_W   = 3,
  parameter int MAX_FAIL = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [KEY_W-1:0]  req_key,
  output logic              res_valid,
  output logic              res_match,
  output logic              locked,
  output logic              wipe_req,
  output logic              commit_req
);
  import pwd_guard_pkg::*;
  localparam int SLOT_SPAN = 1 << SLOT_W;
  localparam int RST_SLOT  = NSLOT - 1;

  logic [NSLOT-1:0]     eq;
  logic [SLOT_SPAN-1:0] eq_ext;
  logic                 is_check, is_rdev, is_rkeys, is_new1, is_new2;
  logic                 slot_hit, reset_hit, check_hit, hit;
  logic                 new1_ok, new2_ok, counted, unlock;
  logic                 tries_wipe, keys_wipe_q;

  assign is_check = req_valid && req_op == OP_CHECK;
  assign is_new1  = req_valid && req_op == OP_NEW1;
  assign is_new2  = req_valid && req_op == OP_NEW2;
  assign is_rdev  = req_valid && req_op == OP_RST_DEV;
  assign is_rkeys = req_valid && req_op == OP_RST_KEYS;

  assign eq_ext    = SLOT_SPAN'(eq);
  assign slot_hit  = eq_ext[req_slot];
  assign reset_hit = eq[RST_SLOT];
  // array slots are barred while locked; reset slot stays usable
  assign check_hit = slot_hit && !(locked && req_slot < SLOT_W'(RST_SLOT));

  always_comb begin
    hit = 1'b0;
    if (is_check)              hit = check_hit;
    else if (is_new1)          hit = new1_ok;
    else if (is_new2)          hit = new2_ok;
    else if (is_rdev || is_rkeys) hit = reset_hit;
  end

  assign counted = is_check || is_rdev || is_rkeys;
  assign unlock  = (is_rdev || is_rkeys) && reset_hit;

  pwd_guard_store #(.KEY_W(KEY_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst(rst),
    .zero_all(is_rkeys && reset_hit),
    .wr_en(is_new2 && new2_ok), .wr_slot(req_slot), .wr_data(req_key),
    .key(req_key), .eq(eq)
  );

  pwd_guard_stage #(.KEY_W(KEY_W), .SLOT_W(SLOT_W)) u_stage (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_slot(req_slot), .req_key(req_key), .check_hit(check_hit),
    .new1_ok(new1_ok), .new2_ok(new2_ok)
  );

  pwd_guard_tries #(.MAX_FAIL(MAX_FAIL)) u_tries (
    .clk(clk), .rst(rst),
    .fail(counted && !hit), .pass(counted && hit), .unlock(unlock),
    .locked(locked), .wipe(tries_wipe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_match   <= 1'b0;
      commit_req  <= 1'b0;
      keys_wipe_q <= 1'b0;
    end else begin
      res_valid   <= req_valid;
      res_match   <= hit;
      commit_req  <= is_new2 && new2_ok;
      keys_wipe_q <= is_rkeys && reset_hit;
    end
  end

  assign wipe_req = tries_wipe | keys_wipe_q;

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R2
  AST_COMMIT_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> (res_valid && res_match)); // R8
  AST_LOCKED_ARRAY_MISS: assert property (@(posedge clk) disable iff (rst)
    (locked && is_check && req_slot < SLOT_W'(RST_SLOT)) |=> !res_match); // R5
endmodule

// File: tb/pwd_guard_tb.sv
`timescale 1ns/1ps
module pwd_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [2:0]  req_slot = '0;
  logic [63:0] req_key = '0;
  logic        res_valid, res_match, locked, wipe_req, commit_req;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  logic [63:0] m_pw [5];
  int          m_cnt;
  bit          m_lock;
  int          m_phase, m_pslot;
  logic [63:0] m_stage;
  bit e_valid, e_match, e_wipe, e_commit;

  always #2.5 clk = ~clk;

  pwd_guard u_dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_slot(req_slot), .req_key(req_key), .res_valid(res_valid), .res_match(res_match),
    .locked(locked), .wipe_req(wipe_req), .commit_req(commit_req));

  task automatic chk(input string nm, input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk("res_valid", res_valid, e_valid, tag);
    chk("res_match", res_match, e_match, tag);
    chk("locked", locked, m_lock, tag);
    chk("wipe_req", wipe_req, e_wipe, tag);
    chk("commit_req", commit_req, e_commit, tag);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_pw[i] = '0;
    m_cnt = 0; m_lock = 0; m_phase = 0; m_pslot = 0; m_stage = '0;
    e_valid = 0; e_match = 0; e_wipe = 0; e_commit = 0;
  endtask

  task automatic step(input int op, input int slot, input logic [63:0] key, input string tag);
    bit h, counted;
    req_valid = 1; req_op = op[2:0]; req_slot = slot[2:0]; req_key = key;
    h = 0; counted = (op == 0 || op == 3 || op == 4);
    case (op)
      0: h = (slot < 5) && key == m_pw[slot] && !(m_lock && slot < 4);
      1: h = (m_phase == 1) && m_pslot == slot;
      2: h = (m_phase == 2) && m_pslot == slot && key == m_stage;
      3, 4: h = (key == m_pw[4]);
      default: h = 0;
    endcase
    e_valid = 1; e_match = h; e_wipe = 0; e_commit = 0;
    if (op == 4 && h) begin
      for (int i = 0; i < 5; i++) m_pw[i] = '0;
      e_wipe = 1; m_cnt = 0; m_lock = 0;
    end else if (op == 3 && h) begin
      m_cnt = 0; m_lock = 0;
    end else if (counted && !m_lock) begin
      if (h) m_cnt = 0;
      else if (m_cnt == 8) begin m_lock = 1; e_wipe = 1; end
      else m_cnt++;
    end
    if (op == 2 && h) begin m_pw[slot] = key; e_commit = 1; end
    if (op == 0 && h) begin m_phase = 1; m_pslot = slot; end
    else if (op == 1 && h) begin m_phase = 2; m_stage = key; end
    else m_phase = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    e_valid = 0; e_match = 0; e_wipe = 0; e_commit = 0;
    @(posedge clk); @(negedge clk);
    compare_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  localparam logic [63:0] KA = 64'hA5A5_0000_1234_5678;
  localparam logic [63:0] KB = 64'h0F0F_F0F0_DEAD_BEEF;
  localparam logic [63:0] KC = 64'h0F0F_F0F0_DEAD_BEEE;
  localparam logic [63:0] KR = 64'h1122_3344_5566_7788;

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    compare_all("R1_in_reset");
    @(negedge clk); rst = 0;
    idle("R1_after_reset");
    // factory keys are zero in every slot
    for (int s = 0; s < 5; s++) step(0, s, 64'd0, "R1_zero_key");
    // basic check, bad slot, illegal op
    step(0, 2, KA, "R3_wrong");
    step(0, 2, 64'd0, "R3_right");
    step(0, 6, 64'd0, "R2_bad_slot");
    step(7, 0, 64'd0, "R2_illegal_op");
    idle("R2_single_cycle");
    // key change slot 0 to KA
    step(0, 0, 64'd0, "R8_auth");
    step(1, 0, KA, "R8_first");
    step(2, 0, KA, "R8_second");
    idle("R8_pulse_end");
    step(0, 0, KA, "R8_new_key");
    step(0, 0, 64'd0, "R8_old_key_gone");
    // mismatched second entry
    step(0, 0, KA, "R9_auth");
    step(1, 0, KB, "R9_first");
    step(2, 0, KC, "R9_differ");
    step(0, 0, KA, "R9_kept");
    // out of order / wrong slot / interrupted
    step(1, 0, KB, "R9_no_auth");
    step(2, 0, KB, "R9_no_first");
    step(0, 1, 64'd0, "R9_auth1");
    step(1, 0, KB, "R9_other_slot");
    step(0, 1, 64'd0, "R9_auth1b");
    idle("R9_gap");
    step(0, 1, 64'd0, "R9_auth1c");
    step(7, 1, 64'd0, "R9_intervene");
    step(1, 1, KB, "R9_after_intervene");
    step(2, 1, KB, "R10_no_count");
    // eight failures tolerated, then a correct key clears the count
    for (int i = 0; i < 8; i++) step(0, i % 4, KC, "R4_fail");
    step(0, 0, KA, "R4_clear");
    // nine failures lock
    for (int i = 0; i < 8; i++) step(0, 3, KC, "R4_fail_again");
    step(4, 4, KC, "R5_ninth_locks");
    idle("R5_wipe_one_cycle");
    step(0, 0, KA, "R5_locked_miss");
    step(0, 2, 64'd0, "R5_locked_miss2");
    step(0, 4, 64'd0, "R6_reset_slot_ok");
    step(3, 4, KC, "R6_wrong_stays");
    step(3, 4, 64'd0, "R6_unlock");
    idle("R6_no_wipe");
    step(0, 0, KA, "R6_keys_kept");
    // change reset key to KR, then reset keys
    step(0, 4, 64'd0, "R8_auth_reset");
    step(1, 4, KR, "R8_first_reset");
    step(2, 4, KR, "R8_second_reset");
    step(3, 4, 64'd0, "R6_old_reset_bad");
    step(4, 4, KR, "R7_reset_keys");
    idle("R7_wipe_end");
    step(0, 0, 64'd0, "R7_zeroed");
    step(0, 4, 64'd0, "R7_reset_zeroed");
    // reset keys while locked
    for (int i = 0; i < 9; i++) step(0, 1, KB, "R5_lock_again");
    step(4, 4, 64'd0, "R7_from_locked");
    step(0, 1, 64'd0, "R7_unlocked");
    idle("R7_end");
    finish_run();
  end
endmodule